// File: doc/BRIEF.md
# APB Requester Transfer Sequencer

This block sits on the requester side of an APB bus and turns single read or write commands into complete bus transfers. A local client offers a command with a valid/ready handshake, carrying an address, a direction bit and write data. The sequencer drives the select, enable, address, direction and write-data lines. It waits out any wait states the slave inserts, then reports the transfer with a one-cycle response that carries the read data and an error flag.

Each transfer passes through a named state machine. A one-cycle set-up phase comes first. An access phase follows, and it lasts as long as the slave holds its ready line low. A command that is waiting when a transfer finishes starts its set-up phase in the very next cycle, so the select line stays high across back-to-back transfers. The block serves one slave select. Reset is synchronous and active low, and it puts the bus into its idle state.

Top module: `apb_seq_top`

## Requirements
- R1: In every cycle that follows a clock edge sampled with `rst_n` low, `psel`, `penable` and `rsp_valid` are low. Outside the two transfer phases, `psel` and `penable` are always low.
- R2: The set-up phase (`psel`=1, `penable`=0) lasts exactly one cycle and is always followed by an access cycle (`psel`=1, `penable`=1).
- R3: The access phase repeats while `pready` is low. The transfer completes at the first edge where `pready` is high, so a slave that inserts N wait cycles gives N+1 access cycles.
- R4: In the set-up cycle, `paddr`, `pwrite` and `pwdata` show the accepted command, with `pwrite`=1 meaning write. They stay unchanged through every access cycle of that transfer.
- R5: `req_ready` is high only when the block is idle, or in an access cycle where `pready` is high. A command is taken at an edge where `req_valid` and `req_ready` are both high. After reset, `req_ready` is high.
- R6: A command accepted at the completing edge starts its set-up phase in the next cycle, so `psel` never drops between back-to-back transfers.
- R7: When no command is taken at the completing edge, `psel` and `penable` are both low in the next cycle.
- R8: `rsp_valid` is high for exactly the one cycle after each completing edge. For a read, `rsp_rdata` holds the `prdata` value sampled at that edge.
- R9: For a write, `rsp_rdata` is zero, whatever `prdata` carries.
- R10: `rsp_err` equals `pslverr` sampled at the completing edge. A `pslverr` value seen during wait cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all outputs change on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Client offers a command |
| req_ready | output | 1 | Sequencer takes the command at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Command address |
| req_wdata | input | DW | Command write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data (zero for writes) |
| rsp_err | output | 1 | Slave error flag of the transfer |
| paddr | output | AW | Bus address |
| psel | output | 1 | Slave select |
| penable | output | 1 | Access-phase marker |
| pwrite | output | 1 | Bus direction |
| pwdata | output | DW | Bus write data |
| pready | input | 1 | Slave ready; low inserts wait cycles |
| prdata | input | DW | Slave read data |
| pslverr | input | 1 | Slave error response |

## Verification
A corrupted state register shows up on `psel`/`penable` within one cycle. Examples are a set-up phase that repeats, an access phase that ends before `pready`, and a select that drops between queued transfers. The bench catches these by counting access cycles against the wait count its slave model inserts for each address. If the command register moves during a wait, the next access cycle shows a different address, direction or data. A wrong response path shows on the cycle after completion, as a missing or doubled `rsp_valid`, stale read data, non-zero data for a write, or an error flag taken from a wait cycle.

// File: rtl/apb_seq_pkg.sv
package apb_seq_pkg;

  // Encoding is fixed: bus phase decode depends on it
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_SETUP  = 2'b01,
    ST_ACCESS = 2'b10
  } seq_state_t;

endpackage

// File: rtl/apb_seq_fsm.sv
module apb_seq_fsm
  import apb_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       pready,
  output seq_state_t state_o,
  output logic       psel_o,
  output logic       penable_o,
  output logic       req_ready_o,
  output logic       accept_o,
  output logic       finish_o
);

  seq_state_t state_q, state_d;
  logic       psel_q, penable_q;

  always_comb begin
    finish_o    = (state_q == ST_ACCESS) && pready;
    req_ready_o = (state_q == ST_IDLE) || finish_o;
    accept_o    = req_valid && req_ready_o;
    state_d     = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept_o) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_ACCESS;
      ST_ACCESS: if (pready) state_d = accept_o ? ST_SETUP : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // Bus control flops are loaded from the next state so they are true registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      psel_q    <= 1'b0;
      penable_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      psel_q    <= (state_d != ST_IDLE);
      penable_q <= (state_d == ST_ACCESS);
    end
  end

  assign state_o   = state_q;
  assign psel_o    = psel_q;
  assign penable_o = penable_q;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!psel_q && !penable_q));

  assert_setup_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP) |-> (psel_q && !penable_q));

  assert_setup_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP) |=> (state_q == ST_ACCESS && psel_q && penable_q));

  assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACCESS && !pready) |=> (state_q == ST_ACCESS));

endmodule

// File: rtl/apb_seq_cmd.sv
module apb_seq_cmd #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [AW-1:0] paddr_o,
  output logic          pwrite_o,
  output logic [DW-1:0] pwdata_o
);

  logic [AW-1:0] addr_q;
  logic          write_q;
  logic [DW-1:0] wdata_q;

  // Loaded only at acceptance, so set-up and every wait cycle see one value
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (load) begin
      addr_q  <= req_addr;
      write_q <= req_write;
      wdata_q <= req_wdata;
    end
  end

  assign paddr_o  = addr_q;
  assign pwrite_o = write_q;
  assign pwdata_o = wdata_q;

endmodule

// File: rtl/apb_seq_rsp.sv
module apb_seq_rsp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          finish,
  input  logic          is_write,
  input  logic [DW-1:0] prdata,
  input  logic          pslverr,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_err_o
);

  logic          valid_q;
  logic [DW-1:0] rdata_q;
  logic          err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= finish;
      if (finish) begin
        rdata_q <= is_write ? '0 : prdata;
        err_q   <= pslverr;
      end
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_rdata_o = rdata_q;
  assign rsp_err_o   = err_q;

  assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> rsp_valid_o);

  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);

  assert_write_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && is_write) |=> (rsp_rdata_o == '0));

endmodule

// File: rtl/apb_seq_top.sv
module apb_seq_top
  import apb_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic [AW-1:0] paddr,
  output logic          psel,
  output logic          penable,
  output logic          pwrite,
  output logic [DW-1:0] pwdata,
  input  logic          pready,
  input  logic [DW-1:0] prdata,
  input  logic          pslverr
);

  seq_state_t state;
  logic       accept;
  logic       finish;

  apb_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .pready      (pready),
    .state_o     (state),
    .psel_o      (psel),
    .penable_o   (penable),
    .req_ready_o (req_ready),
    .accept_o    (accept),
    .finish_o    (finish)
  );

  apb_seq_cmd #(.AW(AW), .DW(DW)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .paddr_o   (paddr),
    .pwrite_o  (pwrite),
    .pwdata_o  (pwdata)
  );

  apb_seq_rsp #(.DW(DW)) u_rsp (
    .clk         (clk),
    .rst_n       (rst_n),
    .finish      (finish),
    .is_write    (pwrite),
    .prdata      (prdata),
    .pslverr     (pslverr),
    .rsp_valid_o (rsp_valid),
    .rsp_rdata_o (rsp_rdata),
    .rsp_err_o   (rsp_err)
  );

  assert_bus_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable) |-> ($stable(paddr) && $stable(pwrite) && $stable(pwdata)));

  assert_ready_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!psel || (penable && pready)));

  assert_idle_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> req_ready);

  assert_err_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_err == $past(pslverr)));

endmodule

// File: tb/apb_seq_top_tb.sv
module apb_seq_top_tb_top;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [AW-1:0] ERR_A   = 32'h3C;  // slave errors here at completion
  localparam logic [AW-1:0] NOISE_A = 32'h38;  // slave raises pslverr only in waits
  localparam logic [DW-1:0] JUNK    = 32'hDEAD_BEEF;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rst_n, req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr, paddr;
  logic [DW-1:0] req_wdata, rsp_rdata, pwdata, prdata;
  logic          rsp_valid, rsp_err, psel, penable, pwrite, pready, pslverr;

  apb_seq_top #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .paddr(paddr), .psel(psel), .penable(penable), .pwrite(pwrite),
    .pwdata(pwdata), .pready(pready), .prdata(prdata), .pslverr(pslverr)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int waits_of(logic [AW-1:0] a);
    return int'(a[3:2]);
  endfunction

  function automatic logic [DW-1:0] init_word(int i);
    return 32'hA500_0000 + DW'(i) * 32'h0101;
  endfunction

  // ---------------- slave model (acts on falling edges) ----------------
  logic [DW-1:0] smem [16];
  logic [DW-1:0] rmem [16];
  int            wcnt;
  bit            cw;
  int            ci;
  logic [DW-1:0] cd;

  initial begin
    for (int i = 0; i < 16; i++) begin
      smem[i] = init_word(i);
      rmem[i] = init_word(i);
    end
    pready = 1'b0; pslverr = 1'b0; prdata = JUNK;
    wcnt = 0; cw = 1'b0; ci = 0; cd = '0;
  end

  always @(negedge clk) begin
    if (pready && cw) smem[ci] = cd;
    if (pready || !rst_n) wcnt = 0;
    pready = 1'b0; pslverr = 1'b0; prdata = JUNK; cw = 1'b0;
    if (rst_n && psel && penable) begin
      if (wcnt == waits_of(paddr)) begin
        pready  = 1'b1;
        if (!pwrite) prdata = smem[paddr[5:2]];
        pslverr = (paddr == ERR_A);
        cw      = pwrite && (paddr != ERR_A);
        ci      = int'(paddr[5:2]);
        cd      = pwdata;
      end else begin
        wcnt++;
        pslverr = (paddr == NOISE_A);
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [AW-1:0] a; logic w; logic [DW-1:0] d; } cmd_t;
  typedef struct { logic [DW-1:0] rd; logic er; logic w; } rsp_t;
  cmd_t cmd_q[$];
  rsp_t rsp_q[$];

  task automatic send(logic w, logic [AW-1:0] a, logic [DW-1:0] d);
    cmd_t c;
    rsp_t r;
    @(negedge clk);
    #1;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    c.a = a; c.w = w; c.d = d;
    cmd_q.push_back(c);
    r.w  = w;
    r.er = (a == ERR_A);
    r.rd = w ? '0 : rmem[a[5:2]];
    if (w && a != ERR_A) rmem[a[5:2]] = d;
    rsp_q.push_back(r);
    #1 req_valid = 1'b0;
  endtask

  task automatic wait_done_idle();
    do begin
      @(negedge clk);
      #3;
    end while (!rsp_valid);
    chk("R7 bus idle after lone completion", {62'd0, psel, penable}, 64'd0);
  endtask

  task automatic drain();
    while (rsp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // ---------------- monitor ----------------
  bit   prev_setup = 1'b0;
  bit   prev_fin = 1'b0;
  bit   burst = 1'b0;
  int   gap_n = 0;
  int   acc_n = 0;
  cmd_t cur;

  always @(negedge clk) begin
    #2;
    if (!rst_n) begin
      prev_setup = 1'b0; prev_fin = 1'b0;
      cmd_q.delete(); rsp_q.delete();
    end else begin
      if (rsp_valid || prev_fin)
        chk("R8 rsp_valid one cycle after completion", 64'(rsp_valid), 64'(prev_fin));
      if (rsp_valid) begin
        if (rsp_q.size() == 0) chk("R8 unexpected response", 64'd1, 64'd0);
        else begin
          rsp_t e;
          e = rsp_q.pop_front();
          chk(e.w ? "R9 write rsp_rdata zero" : "R8 read data", 64'(rsp_rdata), 64'(e.rd));
          chk("R10 rsp_err", 64'(rsp_err), 64'(e.er));
        end
      end
      if (prev_setup)
        chk("R2 setup followed by access", {62'd0, psel, penable}, 64'd3);
      if (psel && !penable) begin
        chk("R5 ready low in setup", 64'(req_ready), 64'd0);
        if (cmd_q.size() == 0) chk("R4 setup without command", 64'd1, 64'd0);
        else begin
          cur = cmd_q.pop_front();
          chk("R4 setup address", 64'(paddr), 64'(cur.a));
          chk("R4 setup dir/data", {31'd0, pwrite, pwdata}, {31'd0, cur.w, cur.d});
        end
        acc_n = 0;
      end
      if (psel && penable) begin
        acc_n++;
        if (paddr !== cur.a || pwrite !== cur.w || pwdata !== cur.d)
          chk("R4 bus held in access", {31'd0, pwrite, pwdata}, {31'd0, cur.w, cur.d});
        if (pready)
          chk("R3 access cycles = waits+1", 64'(acc_n), 64'(waits_of(cur.a) + 1));
      end
      if (burst && !psel && rsp_q.size() > 0) gap_n++;
      prev_setup = psel && !penable;
      prev_fin   = psel && penable && pready;
    end
  end

  // ---------------- watchdog and summary ----------------
  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    #3;
    chk("R1 reset bus quiet", {61'd0, psel, penable, rsp_valid}, 64'd0);
    @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #3;
    chk("R5 ready after reset", 64'(req_ready), 64'd1);

    // lone writes over every wait count
    send(1'b1, 32'h00, 32'h1111_0000); wait_done_idle();
    send(1'b1, 32'h04, 32'h2222_0001); wait_done_idle();
    send(1'b1, 32'h08, 32'h3333_0002); wait_done_idle();
    send(1'b1, 32'h0C, 32'h4444_0003); wait_done_idle();
    // reads back plus untouched word
    send(1'b0, 32'h0C, '0); wait_done_idle();
    send(1'b0, 32'h00, '0); wait_done_idle();
    send(1'b0, 32'h08, '0); wait_done_idle();
    send(1'b0, 32'h14, '0); wait_done_idle();
    // error at completion (R10), and error only during waits (ignored)
    send(1'b1, ERR_A, 32'h5555_AAAA); wait_done_idle();
    send(1'b0, ERR_A, '0); wait_done_idle();
    send(1'b0, NOISE_A, '0); wait_done_idle();

    // back-to-back, zero-wait and mixed (R6)
    burst = 1'b1; gap_n = 0;
    send(1'b1, 32'h10, 32'h6666_0010);
    send(1'b1, 32'h20, 32'h7777_0020);
    send(1'b0, 32'h10, '0);
    send(1'b1, 32'h24, 32'h8888_0024);
    send(1'b0, 32'h20, '0);
    send(1'b0, 32'h24, '0);
    drain();
    burst = 1'b0;
    chk("R6 no select gap in burst", 64'(gap_n), 64'd0);

    // reset in the middle of a waiting access (R1)
    send(1'b0, 32'h0C, '0);
    @(negedge clk);
    @(negedge clk);
    #1 rst_n = 1'b0;
    @(negedge clk);
    #3;
    chk("R1 reset aborts transfer", {61'd0, psel, penable, rsp_valid}, 64'd0);
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #3;
    chk("R5 ready after mid-transfer reset", 64'(req_ready), 64'd1);
    send(1'b0, 32'h0C, '0); wait_done_idle();
    drain();
    chk("R8 all responses delivered", 64'(rsp_q.size()), 64'd0);
    summary();
  end

endmodule